// File: doc/BRIEF.md
# Multiplexed External Bus Controller

This block turns single read and write requests from inside the chip into cycles on an external bus whose address and data share one set of pins. Each bus cycle has two phases. In the address phase the pins carry the 16-bit address and an address latch strobe marks it for an external latch. In the strobe phase the pins carry write data, or are released so the device can drive read data. The strobe phase lasts one cycle plus the wait count of the address area being accessed.

The bus can be used as a 16-bit or an 8-bit data path. On the 8-bit path a halfword access is split into two complete bus cycles. The byte order of halfwords can be switched between big-endian and little-endian. The area wait counts, the bus width and the byte order are sampled when a request is accepted. When the last strobe cycle ends, a done pulse reports completion and, for reads, the assembled read data.

Top module: `mxbus_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, `bus_ale`, `bus_rd`, `bus_wr`, `bus_ad_oe` and `rsp_done` are 0 and `bus_ad_out` is 0.
- R2: A request with `req_valid` high in an idle cycle is accepted. In the next cycle `bus_ale` is 1 for exactly one cycle, `bus_ad_oe` is 1 and `bus_ad_out` carries the beat address. The beat address is `req_addr` for a byte access and `{req_addr[15:1], beat}` for a halfword access, with beat 0 first.
- R3: The strobe phase directly follows the address phase and lasts 1+W cycles. W is the 3-bit field `cfg_wait[3*k+2:3*k]`, where k = `req_addr[15:14]` selects the area.
- R4: During the strobe phase `bus_wr` is 1 for a write and `bus_rd` is 1 for a read. The two are never high together, and neither is high outside the strobe phase. During a read strobe `bus_ad_oe` is 0, and during a write strobe it is 1.
- R5: `rsp_done` is 1 for exactly one cycle, in the cycle after the last strobe cycle. For a read, `rsp_rdata` then holds the data sampled from `bus_ad_in` on the last strobe cycle of each beat.
- R6: On the 16-bit bus (`cfg_bus8`=0) the byte at an even address uses pins [15:8] and the byte at an odd address uses pins [7:0]. A byte write (`req_half`=0) drives `req_wdata[7:0]` on its lane and 0 on the other lane. A byte read returns its lane in `rsp_rdata[7:0]` with the upper byte 0.
- R7: For a halfword access, `req_addr[0]` is ignored. With big-endian order (`cfg_little`=0), the even-address byte is value[15:8]. With little-endian order (`cfg_little`=1), the even-address byte is value[7:0]. This holds for writes and reads on both bus widths.
- R8: On the 8-bit bus (`cfg_bus8`=1) data uses pins [7:0], and pins [15:8] are 0 during a write strobe. A halfword access runs as two full bus cycles, even address first. `rsp_done` comes only after the second cycle.
- R9: While a transfer is in progress, `req_valid` and all request and configuration inputs are ignored. The running transfer completes with the values sampled at acceptance, and the block returns to idle after `rsp_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_addr | input | 16 | Byte address of the transfer |
| req_wdata | input | 16 | Write value (byte in [7:0]) |
| req_half | input | 1 | 1 = halfword, 0 = byte |
| req_write | input | 1 | 1 = write, 0 = read |
| cfg_bus8 | input | 1 | 1 = 8-bit data path, 0 = 16-bit |
| cfg_little | input | 1 | 1 = little-endian halfwords |
| cfg_wait | input | 12 | Four 3-bit wait counts, area k in bits [3k+2:3k] |
| bus_ad_in | input | 16 | Value on the shared pins from the device |
| bus_ad_out | output | 16 | Value driven onto the shared pins |
| bus_ad_oe | output | 1 | Output enable of the shared pins |
| bus_ale | output | 1 | Address latch strobe |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| rsp_rdata | output | 16 | Read result, valid with done |
| rsp_done | output | 1 | One-cycle completion pulse |

## Verification
Directed transfers cover byte accesses at even and odd addresses on the 16-bit bus, which separates the two data lanes. Halfword accesses run in both byte orders on both bus widths, which separates a swapped result from a straight one and a split access from a single one. Wait counts of 0 and 7 in chosen areas check that the strobe length follows the area bits and not a neighbouring field. Seeded random transfers then mix all of these. In some of them the request and configuration inputs are scrambled right after acceptance, which shows whether the block latched its inputs or keeps following the live ones.

// File: rtl/mxbus_pkg.sv
package mxbus_pkg;

    localparam int ADDR_W    = 16;
    localparam int DATA_W    = 16;
    localparam int BYTE_W    = 8;
    localparam int WAIT_W    = 3;
    localparam int AREA_BITS = 2;
    localparam int AREA_NUM  = 1 << AREA_BITS;

    typedef enum logic {
        SZ_BYTE = 1'b0,
        SZ_HALF = 1'b1
    } size_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_STRB = 2'd2,
        PH_DONE = 2'd3
    } phase_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        size_e             size;
        logic              write;
        logic              bus8;
        logic              little;
        logic [WAIT_W-1:0] waits;
    } xfer_t;

    // Pins carried by one write beat.
    function automatic logic [DATA_W-1:0] lane_pack(
        input logic              bus8,
        input logic              little,
        input size_e             size,
        input logic              a0,
        input logic              beat,
        input logic [DATA_W-1:0] v
    );
        logic [BYTE_W-1:0] lo;
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] pick;
        logic [DATA_W-1:0] res;
        lo = v[BYTE_W-1:0];
        hi = v[DATA_W-1:BYTE_W];
        if (bus8) begin
            if (size == SZ_BYTE) pick = lo;
            else                 pick = (beat ^ little) ? lo : hi;
            res = {{BYTE_W{1'b0}}, pick};
        end else if (size == SZ_BYTE) begin
            res = a0 ? {{BYTE_W{1'b0}}, lo} : {lo, {BYTE_W{1'b0}}};
        end else begin
            res = little ? {lo, hi} : v;
        end
        return res;
    endfunction

    // Read word assembled from the pins of the final beat and the held byte.
    function automatic logic [DATA_W-1:0] lane_unpack(
        input logic              bus8,
        input logic              little,
        input size_e             size,
        input logic              a0,
        input logic [BYTE_W-1:0] held,
        input logic [DATA_W-1:0] din
    );
        logic [BYTE_W-1:0] lo;
        logic [BYTE_W-1:0] hi;
        logic [DATA_W-1:0] res;
        lo = din[BYTE_W-1:0];
        hi = din[DATA_W-1:BYTE_W];
        if (bus8) begin
            if (size == SZ_BYTE) res = {{BYTE_W{1'b0}}, lo};
            else                 res = little ? {lo, held} : {held, lo};
        end else if (size == SZ_BYTE) begin
            res = {{BYTE_W{1'b0}}, (a0 ? lo : hi)};
        end else begin
            res = little ? {lo, hi} : din;
        end
        return res;
    endfunction

endpackage

// File: rtl/mxbus_area_wait.sv
module mxbus_area_wait
    import mxbus_pkg::*;
#(
    parameter int AREAS_LOG = AREA_BITS,
    parameter int CNT_W     = WAIT_W,
    localparam int AREAS    = 1 << AREAS_LOG
) (
    input  logic [AREAS_LOG-1:0]   area,
    input  logic [AREAS*CNT_W-1:0] cfg_wait,
    output logic [CNT_W-1:0]       wait_sel
);

    logic [CNT_W-1:0] field [AREAS];

    for (genvar k = 0; k < AREAS; k++) begin : g_field
        assign field[k] = cfg_wait[k*CNT_W +: CNT_W];
    end

    always_comb begin
        wait_sel = '0;
        for (int k = 0; k < AREAS; k++) begin
            if (area == AREAS_LOG'(k)) wait_sel = field[k];
        end
    end

endmodule

// File: rtl/mxbus_lane.sv
module mxbus_lane
    import mxbus_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  size_e             size,
    input  logic              bus8,
    input  logic              little,
    input  logic              beat,
    input  logic [BYTE_W-1:0] held,
    input  logic [DATA_W-1:0] din,
    output logic [ADDR_W-1:0] beat_addr,
    output logic [DATA_W-1:0] wr_lanes,
    output logic [DATA_W-1:0] rd_word
);

    always_comb begin
        if (size == SZ_HALF) beat_addr = {addr[ADDR_W-1:1], beat};
        else                 beat_addr = addr;
    end

    always_comb begin
        wr_lanes = lane_pack(bus8, little, size, beat_addr[0], beat, wdata);
        rd_word  = lane_unpack(bus8, little, size, addr[0], held, din);
    end

    // R8: the upper lane stays quiet on the narrow bus
    always_comb begin
        if (bus8) begin
            a_r8_upper_lane_zero: assert (wr_lanes[DATA_W-1:BYTE_W] == '0);
        end
    end

endmodule

// File: rtl/mxbus_seq.sv
module mxbus_seq
    import mxbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  xfer_t             req_in,
    input  logic [DATA_W-1:0] rd_word,
    input  logic [BYTE_W-1:0] din_lo,
    output phase_e            phase,
    output xfer_t             cur,
    output logic              beat,
    output logic [BYTE_W-1:0] held,
    output logic [DATA_W-1:0] rdata
);

    logic [WAIT_W-1:0] wcnt;
    logic              two_beats;
    logic              last_strb;

    assign two_beats = cur.bus8 && (cur.size == SZ_HALF);
    assign last_strb = (phase == PH_STRB) && (wcnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cur   <= '0;
            beat  <= 1'b0;
            wcnt  <= '0;
            held  <= '0;
            rdata <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (req_valid) begin
                        cur   <= req_in;
                        beat  <= 1'b0;
                        phase <= PH_ADDR;
                    end
                end
                PH_ADDR: begin
                    wcnt  <= cur.waits;
                    phase <= PH_STRB;
                end
                PH_STRB: begin
                    if (last_strb) begin
                        if (two_beats && !beat) begin
                            if (!cur.write) held <= din_lo;
                            beat  <= 1'b1;
                            phase <= PH_ADDR;
                        end else begin
                            if (!cur.write) rdata <= rd_word;
                            phase <= PH_DONE;
                        end
                    end else begin
                        wcnt <= wcnt - 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // Length of the current strobe run, kept for the checks below.
    logic [WAIT_W:0] run_q;
    always_ff @(posedge clk) begin
        if (rst)                   run_q <= '0;
        else if (phase == PH_STRB) run_q <= run_q + 1'b1;
        else                       run_q <= '0;
    end

    // R3: strobe keeps going until it has lasted 1+W cycles
    a_r3_strobe_holds: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_STRB && run_q < {1'b0, cur.waits}) |=> (phase == PH_STRB));

    // R3: and then it stops
    a_r3_strobe_ends: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_STRB && run_q == {1'b0, cur.waits}) |=> (phase != PH_STRB));

    // R9: the latched transfer does not move while busy
    a_r9_latched_stable: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_IDLE && $past(phase) != PH_IDLE) |-> $stable(cur));

    // R8: a second beat only exists for a split access
    a_r8_second_beat: assert property (@(posedge clk) disable iff (rst)
        beat |-> two_beats);

endmodule

// File: rtl/mxbus_ctrl.sv
module mxbus_ctrl
    import mxbus_pkg::*;
#(
    parameter int AREAS_LOG = AREA_BITS,
    localparam int AREAS    = 1 << AREAS_LOG
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req_valid,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [DATA_W-1:0]       req_wdata,
    input  logic                    req_half,
    input  logic                    req_write,
    input  logic                    cfg_bus8,
    input  logic                    cfg_little,
    input  logic [AREAS*WAIT_W-1:0] cfg_wait,
    input  logic [DATA_W-1:0]       bus_ad_in,
    output logic [DATA_W-1:0]       bus_ad_out,
    output logic                    bus_ad_oe,
    output logic                    bus_ale,
    output logic                    bus_rd,
    output logic                    bus_wr,
    output logic [DATA_W-1:0]       rsp_rdata,
    output logic                    rsp_done
);

    logic [WAIT_W-1:0] area_wait;
    xfer_t             req_x;
    xfer_t             cur;
    phase_e            phase;
    logic              beat;
    logic [BYTE_W-1:0] held;
    logic [ADDR_W-1:0] beat_addr;
    logic [DATA_W-1:0] wr_lanes;
    logic [DATA_W-1:0] rd_word;

    mxbus_area_wait #(
        .AREAS_LOG (AREAS_LOG),
        .CNT_W     (WAIT_W)
    ) u_area (
        .area     (req_addr[ADDR_W-1 -: AREAS_LOG]),
        .cfg_wait (cfg_wait),
        .wait_sel (area_wait)
    );

    always_comb begin
        req_x.addr   = req_addr;
        req_x.wdata  = req_wdata;
        req_x.size   = req_half ? SZ_HALF : SZ_BYTE;
        req_x.write  = req_write;
        req_x.bus8   = cfg_bus8;
        req_x.little = cfg_little;
        req_x.waits  = area_wait;
    end

    mxbus_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_in    (req_x),
        .rd_word   (rd_word),
        .din_lo    (bus_ad_in[BYTE_W-1:0]),
        .phase     (phase),
        .cur       (cur),
        .beat      (beat),
        .held      (held),
        .rdata     (rsp_rdata)
    );

    mxbus_lane u_lane (
        .addr      (cur.addr),
        .wdata     (cur.wdata),
        .size      (cur.size),
        .bus8      (cur.bus8),
        .little    (cur.little),
        .beat      (beat),
        .held      (held),
        .din       (bus_ad_in),
        .beat_addr (beat_addr),
        .wr_lanes  (wr_lanes),
        .rd_word   (rd_word)
    );

    always_comb begin
        bus_ale  = (phase == PH_ADDR);
        bus_rd   = (phase == PH_STRB) && !cur.write;
        bus_wr   = (phase == PH_STRB) &&  cur.write;
        rsp_done = (phase == PH_DONE);
        bus_ad_oe = bus_ale || bus_wr;
        if (bus_ale)     bus_ad_out = beat_addr;
        else if (bus_wr) bus_ad_out = wr_lanes;
        else             bus_ad_out = '0;
    end

    // R4: strobes exclusive
    a_r4_strobe_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(bus_rd && bus_wr));

    // R4: pins released while the device drives them
    a_r4_read_released: assert property (@(posedge clk) disable iff (rst)
        bus_rd |-> !bus_ad_oe);

    // R2: address latch pulse is one cycle and a strobe follows it
    a_r2_ale_then_strobe: assert property (@(posedge clk) disable iff (rst)
        bus_ale |=> (!bus_ale && (bus_rd || bus_wr)));

    // R5: done is a single pulse right after a strobe
    a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done);

    a_r5_done_after_strobe: assert property (@(posedge clk) disable iff (rst)
        rsp_done |-> $past(bus_rd || bus_wr));

endmodule

// File: tb/mxbus_ctrl_tb.sv
`timescale 1ns/1ps
module mxbus_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_half = 1'b0;
    logic        req_write = 1'b0;
    logic        cfg_bus8 = 1'b0;
    logic        cfg_little = 1'b0;
    logic [11:0] cfg_wait = '0;
    logic [15:0] bus_ad_in = '0;
    logic [15:0] bus_ad_out;
    logic        bus_ad_oe;
    logic        bus_ale;
    logic        bus_rd;
    logic        bus_wr;
    logic [15:0] rsp_rdata;
    logic        rsp_done;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    mxbus_ctrl u_dut (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .req_half   (req_half),
        .req_write  (req_write),
        .cfg_bus8   (cfg_bus8),
        .cfg_little (cfg_little),
        .cfg_wait   (cfg_wait),
        .bus_ad_in  (bus_ad_in),
        .bus_ad_out (bus_ad_out),
        .bus_ad_oe  (bus_ad_oe),
        .bus_ale    (bus_ale),
        .bus_rd     (bus_rd),
        .bus_wr     (bus_wr),
        .rsp_rdata  (rsp_rdata),
        .rsp_done   (rsp_done)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Contents of the device at each byte address.
    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        return a[7:0] ^ (a[15:8] + 8'h3C);
    endfunction

    // Memory byte the write places at address x.
    function automatic logic [7:0] byte_for(input logic le, input logic half,
                                            input logic [15:0] v, input logic odd);
        if (!half) return v[7:0];
        if (odd)   return le ? v[15:8] : v[7:0];
        return le ? v[7:0] : v[15:8];
    endfunction

    function automatic logic [15:0] exp_lanes(input logic b8, input logic le, input logic half,
                                              input logic [15:0] a, input logic [15:0] ba,
                                              input logic [15:0] v);
        if (b8)   return {8'h00, byte_for(le, half, v, ba[0])};
        if (half) return {byte_for(le, 1'b1, v, 1'b0), byte_for(le, 1'b1, v, 1'b1)};
        return a[0] ? {8'h00, v[7:0]} : {v[7:0], 8'h00};
    endfunction

    function automatic logic [15:0] dev_pins(input logic b8, input logic [15:0] ba);
        if (b8) return {8'hA5, mem_byte(ba)};
        return {mem_byte({ba[15:1], 1'b0}), mem_byte({ba[15:1], 1'b1})};
    endfunction

    function automatic logic [15:0] exp_read(input logic le, input logic half, input logic [15:0] a);
        logic [7:0] ev;
        logic [7:0] od;
        ev = mem_byte({a[15:1], 1'b0});
        od = mem_byte({a[15:1], 1'b1});
        if (!half) return {8'h00, mem_byte(a)};
        return le ? {od, ev} : {ev, od};
    endfunction

    task automatic txn(input logic [15:0] a, input logic [15:0] v, input logic half,
                       input logic wr, input logic b8, input logic le,
                       input logic [11:0] wcfg, input logic disturb);
        int w;
        int nb;
        string lt;
        logic [15:0] ba;
        w  = int'(wcfg[int'(a[15:14])*3 +: 3]);
        nb = (b8 && half) ? 2 : 1;
        lt = b8 ? "R8 lanes" : (half ? "R7 lanes" : "R6 lanes");
        req_addr = a; req_wdata = v; req_half = half; req_write = wr;
        cfg_bus8 = b8; cfg_little = le; cfg_wait = wcfg; req_valid = 1'b1;
        @(posedge clk); @(negedge clk);
        if (disturb) begin
            req_addr   = 16'($urandom);
            req_wdata  = 16'($urandom);
            req_half   = ~half;
            req_write  = ~wr;
            cfg_bus8   = ~b8;
            cfg_little = ~le;
            cfg_wait   = 12'($urandom);
        end else begin
            req_valid = 1'b0;
        end
        for (int b = 0; b < nb; b++) begin
            ba = half ? {a[15:1], b[0]} : a;
            if (b > 0) begin @(posedge clk); @(negedge clk); end
            chk("R2 ale high", {31'd0, bus_ale}, 32'd1);
            chk("R2 address on pins", {15'd0, bus_ad_oe, bus_ad_out}, {15'd0, 1'b1, ba});
            chk("R4 no strobe in address phase", {30'd0, bus_rd, bus_wr}, 32'd0);
            for (int s = 0; s <= w; s++) begin
                @(posedge clk); @(negedge clk);
                chk("R3 strobe active", {29'd0, bus_ale, bus_rd, bus_wr}, {29'd0, 1'b0, !wr, wr});
                if (wr) begin
                    chk(lt, {15'd0, bus_ad_oe, bus_ad_out}, {15'd0, 1'b1, exp_lanes(b8, le, half, a, ba, v)});
                end else begin
                    chk("R4 pins released on read", {31'd0, bus_ad_oe}, 32'd0);
                    bus_ad_in = dev_pins(b8, ba);
                end
            end
        end
        @(posedge clk); @(negedge clk);
        chk("R5 done pulse", {29'd0, rsp_done, bus_rd, bus_wr}, 32'd4);
        if (!wr) chk(disturb ? "R9 read data under scrambled inputs" : "R5 read data",
                     {16'd0, rsp_rdata}, {16'd0, exp_read(le, half, a)});
        req_valid = 1'b0;
        bus_ad_in = 16'h0000;
        @(posedge clk); @(negedge clk);
        chk("R9 idle after done", {30'd0, bus_ale, rsp_done}, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1D2C_3B4A));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 quiet in reset", {15'd0, bus_ale, bus_rd, bus_wr, bus_ad_oe, rsp_done, bus_ad_out},
            32'd0);
        rst = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R1 quiet after reset", {15'd0, bus_ale, bus_rd, bus_wr, bus_ad_oe, rsp_done, bus_ad_out},
            32'd0);

        // R6 byte lanes on the wide bus
        txn(16'h0124, 16'h00AB, 1'b0, 1'b1, 1'b0, 1'b0, 12'o0000, 1'b0);
        txn(16'h0125, 16'h00CD, 1'b0, 1'b1, 1'b0, 1'b0, 12'o0000, 1'b0);
        txn(16'h0342, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 12'o0000, 1'b0);
        txn(16'h0343, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 12'o0000, 1'b0);
        // R7 halfword byte order on the wide bus, odd address bit ignored
        txn(16'h4011, 16'h1234, 1'b1, 1'b1, 1'b0, 1'b0, 12'o0000, 1'b0);
        txn(16'h4011, 16'h1234, 1'b1, 1'b1, 1'b0, 1'b1, 12'o0000, 1'b0);
        txn(16'h4020, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0, 12'o0000, 1'b0);
        txn(16'h4020, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b1, 12'o0000, 1'b0);
        // R8 split halfword on the narrow bus
        txn(16'h8100, 16'hBEEF, 1'b1, 1'b1, 1'b1, 1'b0, 12'o0000, 1'b0);
        txn(16'h8100, 16'hBEEF, 1'b1, 1'b1, 1'b1, 1'b1, 12'o0000, 1'b0);
        txn(16'h8203, 16'h0000, 1'b1, 1'b0, 1'b1, 1'b0, 12'o0000, 1'b0);
        txn(16'h8203, 16'h0000, 1'b1, 1'b0, 1'b1, 1'b1, 12'o0000, 1'b0);
        txn(16'h8207, 16'h0077, 1'b0, 1'b1, 1'b1, 1'b0, 12'o0000, 1'b0);
        // R3 per-area waits: only the addressed area's field counts
        txn(16'h0010, 16'h5A5A, 1'b1, 1'b1, 1'b0, 1'b0, 12'o0007, 1'b0);
        txn(16'h4010, 16'h5A5A, 1'b1, 1'b0, 1'b0, 1'b0, 12'o7707, 1'b0);
        txn(16'h8010, 16'h5A5A, 1'b1, 1'b1, 1'b1, 1'b0, 12'o0700, 1'b0);
        txn(16'hC010, 16'h5A5A, 1'b1, 1'b0, 1'b1, 1'b1, 12'o7000, 1'b0);
        txn(16'hC010, 16'h5A5A, 1'b0, 1'b0, 1'b0, 1'b0, 12'o0777, 1'b0);
        // R9 inputs scrambled during a transfer
        txn(16'h8001, 16'hA1B2, 1'b1, 1'b0, 1'b1, 1'b1, 12'o3210, 1'b1);
        txn(16'h4003, 16'hC3D4, 1'b1, 1'b1, 1'b0, 1'b0, 12'o3210, 1'b1);

        for (int i = 0; i < 300; i++) begin
            txn(16'($urandom), 16'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                1'($urandom), 12'($urandom), ($urandom % 4) == 0);
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule